// File: doc/BRIEF.md
# Power-On Strap Latch and Power-Down Sequencer

The block samples five shared pad levels once, when the power-good input first rises after reset. It stores them in a 5-bit latch and then hands the pads over to clock output duty by raising their output enable. From then on the same power-good input is read as an asynchronous, active-low power-down request. The block synchronizes the request, parks all clock outputs low on the next falling edge of the internal processor clock phase, and then turns off the synthesizer and the oscillator one after the other. On wake it brings them back in the reverse order.

The latched straps carry three frequency-select bits, an output-select bit and a voltage-select bit. The final 4-bit frequency select comes either from the latched straps or from a register-supplied value, as chosen by a source bit. The two clock-stop requests gate the processor and bus clock enables only while the block is running. During power-down they have no effect.

Top module: `strap_pd_ctrl`

## Requirements
- R1: While reset is held, and after it until power-good is seen high, `strap_oe_o`, `clk_run_o`, `synth_off_o` and `osc_off_o` are all 0.
- R2: The latch captures `strap_i` on the clock edge that follows the synchronized power-good by one cycle, which is SYNC_STAGES+1 edges after the input rises. On that same edge `strap_oe_o` and `clk_run_o` go to 1. With both stop inputs high, `cpu_run_o` and `pci_run_o` are then also 1.
- R3: Field layout of the latch: `strap_i[2:0]` is the frequency strap, `strap_i[3]` the output select (driven on `out_sel_o`) and `strap_i[4]` the voltage select (driven on `volt_sel_o`). After capture, changes on `strap_i` do not change any output.
- R4: `freq_sel_o` equals `freq_reg_i` when `freq_src_i` is 1. When `freq_src_i` is 0 it equals `{STRAP_FS3, strap[2:0]}` (STRAP_FS3 defaults to 0). The select reacts combinationally.
- R5: After power-good falls, `clk_run_o` stays 1 until a clock edge where `cpu_ph_i` is sampled 0 having been 1 on the previous edge; it drops on that edge. If power-good returns high before such a fall, the block goes back to running, and later falls of `cpu_ph_i` do not stop the clocks.
- R6: `synth_off_o` rises SEQ_CYC edges after `clk_run_o` falls, and `osc_off_o` rises SEQ_CYC edges after `synth_off_o`.
- R7: In power-down, `osc_off_o` clears SYNC_STAGES+1 edges after power-good rises. `synth_off_o` clears SEQ_CYC edges later, and `clk_run_o` returns to 1 LOCK_CYC edges after that.
- R8: The latch and `strap_oe_o` keep their values through power-down and wake; only a new reset allows a new capture.
- R9: While the oscillator is off, `cpu_stop_ni` and `pci_stop_ni` have no effect: `cpu_run_o` and `pci_run_o` stay 0 and `osc_off_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| pwrgd_pd_i | input | 1 | Power-good before capture, active-low power-down request after |
| strap_i | input | 5 | Pad levels sampled at capture |
| cpu_ph_i | input | 1 | Internal processor clock phase, synchronous to clk_i |
| cpu_stop_ni | input | 1 | Asynchronous active-low processor clock stop |
| pci_stop_ni | input | 1 | Asynchronous active-low bus clock stop |
| freq_src_i | input | 1 | 1 selects the register frequency value |
| freq_reg_i | input | 4 | Register frequency value |
| strap_oe_o | output | 1 | Output enable for the shared pads |
| freq_sel_o | output | 4 | Final frequency select |
| out_sel_o | output | 1 | Latched output-select strap |
| volt_sel_o | output | 1 | Latched voltage-select strap |
| clk_run_o | output | 1 | 1 lets all clock outputs toggle, 0 parks them low |
| cpu_run_o | output | 1 | Processor clock enable |
| pci_run_o | output | 1 | Bus clock enable |
| synth_off_o | output | 1 | Synthesizer off indication |
| osc_off_o | output | 1 | Oscillator off indication |

## Verification
The capture is tried with random strap words over repeated resets; each field is compared at its own output, so a swapped or shifted field shows up. The straps are then inverted to separate a true latch from a pass-through. The frequency mux is driven with random register values under both source settings, plus all-ones and all-zeros, which separates the two sources and exposes bit-order errors. The power-down is run with the processor phase held high for a while, which tells waiting-for-edge apart from immediate parking, and with an aborted request. Stop-input toggling and strap changes inside power-down show that neither reaches the outputs, and exact edge counts on every step separate the down order from the wake order.

// File: rtl/strap_pd_pkg.sv
`timescale 1ns/1ps
package strap_pd_pkg;
  localparam int STRAP_W = 5;

  typedef struct packed {
    logic       volt;
    logic       outsel;
    logic [2:0] fs;
  } strap_t;

  typedef enum logic [2:0] {
    ST_WAIT, ST_RUN, ST_PARK, ST_SYN_DN, ST_OSC_DN, ST_DOWN, ST_OSC_UP, ST_LOCK
  } seq_state_e;
endpackage

// File: rtl/strap_sync.sv
`timescale 1ns/1ps
module strap_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] rst_val_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= rst_val_i;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/strap_latch.sv
`timescale 1ns/1ps
module strap_latch
  import strap_pd_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   cap_i,
  input  strap_t pad_i,
  output strap_t val_o
);
  strap_t val_q;
  logic   done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      done_q <= 1'b0;
    end else if (cap_i && !done_q) begin
      val_q  <= pad_i;
      done_q <= 1'b1;
    end
  end

  assign val_o = val_q;

  // R8: once loaded, never reloaded without reset
  a_r8_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> $stable(val_q));
  // R8: the capture strobe fires once per reset
  a_r8_single_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !cap_i);
endmodule

// File: rtl/pd_seq.sv
`timescale 1ns/1ps
module pd_seq
  import strap_pd_pkg::*;
#(
  parameter int SEQ_CYC  = 4,
  parameter int LOCK_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pg_i,
  input  logic cpu_ph_i,
  output logic cap_o,
  output logic oe_o,
  output logic run_o,
  output logic synth_off_o,
  output logic osc_off_o
);
  localparam int MAX_LIM = (SEQ_CYC > LOCK_CYC) ? SEQ_CYC : LOCK_CYC;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);
  localparam logic [CNT_W-1:0] SEQ_LAST  = CNT_W'(SEQ_CYC - 1);
  localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYC - 1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             cpu_q, oe_q, run_q, syn_q, osc_q;
  logic             cpu_fall;

  assign cpu_fall = cpu_q && !cpu_ph_i;
  assign cap_o    = (state_q == ST_WAIT) && pg_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      cnt_q   <= '0;
      cpu_q   <= 1'b0;
      oe_q    <= 1'b0;
      run_q   <= 1'b0;
      syn_q   <= 1'b0;
      osc_q   <= 1'b0;
    end else begin
      cpu_q <= cpu_ph_i;
      cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        ST_WAIT: if (pg_i) begin
          state_q <= ST_RUN;
          oe_q    <= 1'b1;
          run_q   <= 1'b1;
        end
        ST_RUN: if (!pg_i) state_q <= ST_PARK;
        ST_PARK: begin
          if (pg_i) state_q <= ST_RUN;
          else if (cpu_fall) begin
            run_q   <= 1'b0;
            cnt_q   <= '0;
            state_q <= ST_SYN_DN;
          end
        end
        ST_SYN_DN: if (cnt_q == SEQ_LAST) begin
          syn_q   <= 1'b1;
          cnt_q   <= '0;
          state_q <= ST_OSC_DN;
        end
        ST_OSC_DN: if (cnt_q == SEQ_LAST) begin
          osc_q   <= 1'b1;
          state_q <= ST_DOWN;
        end
        ST_DOWN: if (pg_i) begin
          osc_q   <= 1'b0;
          cnt_q   <= '0;
          state_q <= ST_OSC_UP;
        end
        ST_OSC_UP: if (cnt_q == SEQ_LAST) begin
          syn_q   <= 1'b0;
          cnt_q   <= '0;
          state_q <= ST_LOCK;
        end
        ST_LOCK: if (cnt_q == LOCK_LAST) begin
          run_q   <= 1'b1;
          state_q <= ST_RUN;
        end
        default: state_q <= ST_WAIT;
      endcase
    end
  end

  assign oe_o        = oe_q;
  assign run_o       = run_q;
  assign synth_off_o = syn_q;
  assign osc_off_o   = osc_q;

  // R2: pads stay outputs once turned over
  a_r2_oe_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |=> oe_q);
  // R5: clocks park only on a processor phase fall
  a_r5_park_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_q) |-> $past(cpu_fall));
  // R6: synthesizer off only with clocks parked
  a_r6_synth_after_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    syn_q |-> !run_q);
  // R6: oscillator off only with synthesizer off
  a_r6_osc_after_synth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_q |-> syn_q);
  // R7: synthesizer wakes after the oscillator
  a_r7_wake_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(syn_q) |-> !osc_q);
  // R1: nothing runs before the pads are turned over
  a_r1_run_needs_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> oe_q);
endmodule

// File: rtl/strap_pd_ctrl.sv
`timescale 1ns/1ps
module strap_pd_ctrl
  import strap_pd_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         SEQ_CYC     = 4,
  parameter int         LOCK_CYC    = 16,
  parameter logic       STRAP_FS3   = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pwrgd_pd_i,
  input  logic [STRAP_W-1:0]   strap_i,
  input  logic                 cpu_ph_i,
  input  logic                 cpu_stop_ni,
  input  logic                 pci_stop_ni,
  input  logic                 freq_src_i,
  input  logic [3:0]           freq_reg_i,
  output logic                 strap_oe_o,
  output logic [3:0]           freq_sel_o,
  output logic                 out_sel_o,
  output logic                 volt_sel_o,
  output logic                 clk_run_o,
  output logic                 cpu_run_o,
  output logic                 pci_run_o,
  output logic                 synth_off_o,
  output logic                 osc_off_o
);
  logic [2:0] async_in, async_s;
  logic       pg_s, cpu_stop_s, pci_stop_s, cap;
  strap_t     strap_val;

  assign async_in = {pci_stop_ni, cpu_stop_ni, pwrgd_pd_i};

  strap_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(async_in), .rst_val_i(3'b110), .q_o(async_s)
  );
  assign {pci_stop_s, cpu_stop_s, pg_s} = async_s;

  pd_seq #(.SEQ_CYC(SEQ_CYC), .LOCK_CYC(LOCK_CYC)) i_seq (
    .clk_i, .rst_ni, .pg_i(pg_s), .cpu_ph_i,
    .cap_o(cap), .oe_o(strap_oe_o), .run_o(clk_run_o),
    .synth_off_o, .osc_off_o
  );

  strap_latch i_latch (
    .clk_i, .rst_ni, .cap_i(cap), .pad_i(strap_t'(strap_i)), .val_o(strap_val)
  );

  assign freq_sel_o = freq_src_i ? freq_reg_i : {STRAP_FS3, strap_val.fs};
  assign out_sel_o  = strap_val.outsel;
  assign volt_sel_o = strap_val.volt;
  assign cpu_run_o  = clk_run_o && cpu_stop_s;
  assign pci_run_o  = clk_run_o && pci_stop_s;

  // R9: stop inputs cannot enable clocks while the oscillator is off
  a_r9_stop_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_off_o |-> (!cpu_run_o && !pci_run_o));
  // R4: strap source never shows a register value
  a_r4_strap_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !freq_src_i |-> (freq_sel_o[3] == STRAP_FS3));
endmodule

// File: tb/test_strap_pd_ctrl.sv
`timescale 1ns/1ps
module test_strap_pd_ctrl;
  localparam int SYNC = 2, SEQ = 4, LOCK = 16;

  logic clk_i = 1'b0, rst_ni = 1'b0, pwrgd_pd_i = 1'b0, cpu_ph_i = 1'b1;
  logic cpu_stop_ni = 1'b1, pci_stop_ni = 1'b1, freq_src_i = 1'b0;
  logic [4:0] strap_i = '0;
  logic [3:0] freq_reg_i = '0;
  logic strap_oe_o, out_sel_o, volt_sel_o, clk_run_o, cpu_run_o, pci_run_o;
  logic synth_off_o, osc_off_o;
  logic [3:0] freq_sel_o;

  int checks = 0, errors = 0;
  logic [4:0] cap_val;

  always #2.5 clk_i = ~clk_i;

  strap_pd_ctrl #(.SYNC_STAGES(SYNC), .SEQ_CYC(SEQ), .LOCK_CYC(LOCK)) i_strap_pd_ctrl (
    .clk_i, .rst_ni, .pwrgd_pd_i, .strap_i, .cpu_ph_i, .cpu_stop_ni, .pci_stop_ni,
    .freq_src_i, .freq_reg_i, .strap_oe_o, .freq_sel_o, .out_sel_o, .volt_sel_o,
    .clk_run_o, .cpu_run_o, .pci_run_o, .synth_off_o, .osc_off_o
  );

  function automatic logic [3:0] exp_freq(logic src, logic [3:0] rv, logic [4:0] st);
    return src ? rv : {1'b0, st[2:0]};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; pwrgd_pd_i = 1'b0;
    step(2);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic capture(logic [4:0] v);
    strap_i = v; pwrgd_pd_i = 1'b1; cap_val = v;
    step(SYNC);
    chk("R2 oe before capture", {7'b0, strap_oe_o}, 8'd0);
    step(1);
    chk("R2 oe at capture", {7'b0, strap_oe_o}, 8'd1);
    chk("R2 run at capture", {5'b0, clk_run_o, cpu_run_o, pci_run_o}, 8'd7);
  endtask

  task automatic chk_fields(string req);
    chk(req, {5'b0, volt_sel_o, out_sel_o, 1'b0}, {5'b0, cap_val[4], cap_val[3], 1'b0});
    chk(req, {4'b0, freq_sel_o}, {4'b0, exp_freq(freq_src_i, freq_reg_i, cap_val)});
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    step(1);
    chk("R1 in reset", {4'b0, strap_oe_o, clk_run_o, synth_off_o, osc_off_o}, 8'd0);
    rst_ni = 1'b1;
    step(6);
    chk("R1 wait for power-good", {4'b0, strap_oe_o, clk_run_o, synth_off_o, osc_off_o}, 8'd0);

    // random captures across resets (R3, R4)
    for (int i = 0; i < 8; i++) begin
      do_reset();
      capture(5'($urandom));
      freq_src_i = 1'b0;
      #1 chk_fields("R3 fields");
      strap_i = ~cap_val;
      step(3);
      chk_fields("R3 straps ignored after capture");
      for (int j = 0; j < 4; j++) begin
        freq_src_i = 1'($urandom);
        freq_reg_i = 4'($urandom);
        #1 chk("R4 freq mux", {4'b0, freq_sel_o},
               {4'b0, exp_freq(freq_src_i, freq_reg_i, cap_val)});
      end
    end

    // directed mux corners
    do_reset();
    capture(5'b10101);
    freq_src_i = 1'b1; freq_reg_i = 4'hF;
    #1 chk("R4 register all ones", {4'b0, freq_sel_o}, 8'h0F);
    freq_reg_i = 4'h0;
    #1 chk("R4 register zero", {4'b0, freq_sel_o}, 8'h00);
    freq_src_i = 1'b0; freq_reg_i = 4'hF;
    #1 chk("R4 strap source", {4'b0, freq_sel_o}, 8'h05);

    // aborted power-down request (R5)
    cpu_ph_i = 1'b1;
    pwrgd_pd_i = 1'b0;
    step(SYNC + 2);
    pwrgd_pd_i = 1'b1;
    step(SYNC + 2);
    cpu_ph_i = 1'b0;
    step(3);
    chk("R5 aborted request keeps clocks", {7'b0, clk_run_o}, 8'd1);
    cpu_ph_i = 1'b1;
    step(2);

    // power-down sequence (R5, R6)
    pwrgd_pd_i = 1'b0;
    step(SYNC + 5);
    chk("R5 waits for phase fall", {7'b0, clk_run_o}, 8'd1);
    cpu_ph_i = 1'b0;
    step(1);
    chk("R5 parked on fall", {6'b0, clk_run_o, synth_off_o}, 8'd0);
    step(SEQ - 1);
    chk("R6 synth not yet off", {7'b0, synth_off_o}, 8'd0);
    step(1);
    chk("R6 synth off", {6'b0, synth_off_o, osc_off_o}, 8'd2);
    step(SEQ - 1);
    chk("R6 osc not yet off", {7'b0, osc_off_o}, 8'd0);
    step(1);
    chk("R6 osc off", {7'b0, osc_off_o}, 8'd1);

    // stop inputs and straps during power-down (R9, R8)
    for (int k = 0; k < 6; k++) begin
      cpu_stop_ni = 1'($urandom);
      pci_stop_ni = 1'($urandom);
      strap_i = 5'($urandom);
      step(1);
      chk("R9 stops ignored in power-down", {5'b0, cpu_run_o, pci_run_o, osc_off_o}, 8'd1);
    end
    cpu_stop_ni = 1'b1; pci_stop_ni = 1'b1;
    step(SYNC);
    chk("R9 stops high still parked", {6'b0, cpu_run_o, pci_run_o}, 8'd0);
    chk("R8 oe held in power-down", {7'b0, strap_oe_o}, 8'd1);
    chk_fields("R8 latch held in power-down");

    // wake (R7, R8)
    pwrgd_pd_i = 1'b1;
    step(SYNC);
    chk("R7 osc still off", {7'b0, osc_off_o}, 8'd1);
    step(1);
    chk("R7 osc on first", {6'b0, synth_off_o, osc_off_o}, 8'd2);
    step(SEQ - 1);
    chk("R7 synth still off", {7'b0, synth_off_o}, 8'd1);
    step(1);
    chk("R7 synth on", {6'b0, synth_off_o, clk_run_o}, 8'd0);
    step(LOCK - 1);
    chk("R7 lock wait", {7'b0, clk_run_o}, 8'd0);
    step(1);
    chk("R7 clocks run", {5'b0, clk_run_o, cpu_run_o, pci_run_o}, 8'd7);
    step(SYNC + 2);
    chk("R8 no recapture on wake", {7'b0, strap_oe_o}, 8'd1);
    chk_fields("R8 latch after wake");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule